// File: doc/BRIEF.md
# Temperature-Compensation Conversion Scheduler

This block decides when the oscillator's temperature compensation runs. It asks an external sensor interface for a measurement and stores the 10-bit result in two read-only temperature registers. It then forms a capacitor trim code by adding a signed aging offset to a base capacitance value. The base value comes from an external lookup that is indexed by the stored temperature code.

A conversion runs once straight after reset. After that, one runs automatically every 64 ticks of a once-per-second enable. Software can also force a conversion by setting a request bit. This bit reads back as busy until the result has been written. When the device runs from its battery and the battery-conversion-disable bit is set, automatic conversions are skipped. The trim output is only refreshed when the measured temperature differs from the previous conversion, when the conversion was requested by software, or on the first conversion after reset.

Top module: `tcomp_sched`

## Requirements
- R1: Reset clears the following: both temperature registers (0 °C), the trim code, the aging register, the control register and the busy bit. A conversion is then started without any tick arriving.
- R2: Each completed conversion writes the code into the temperature registers. `temp_msb` holds code bits 9:2, the signed integer degrees. `temp_lsb` bits 7:6 hold code bits 1:0, the quarter degrees, and `temp_lsb` bits 5:0 always read 0. `temp_code` presents the stored 10-bit code to the lookup.
- R3: An automatic conversion starts on the 64th `sec_tick` counted after the previous automatic conversion started (or was skipped), and not earlier.
- R4: A `conv_req` pulse sets `conv_busy` and starts a conversion, ahead of any pending automatic one. `conv_busy` stays 1 until the trim write of that conversion and drops one cycle after the `meas_done` that completes it.
- R5: While `on_battery` is 1 and control bit 0 is 1, an automatic conversion that falls due is skipped: there is no `meas_req` and the registers do not change. User conversions still run.
- R6: After an automatic conversion, `trim` changes only if the new code differs from the code stored before it. A user conversion, and the first conversion after reset, always refresh `trim`. `trim` never changes except exactly two clock edges after a sampled `meas_done`.
- R7: The refreshed trim equals `base_cap` plus the sign-extended `aging_q`, clamped to the range 0 to 2^TW-1 instead of wrapping.
- R8: `aging_wr` loads `wdata` into the aging register. `ctl_wr` loads `wdata[0]` into control bit 0. Control bits 7:1 always read 0.
- R9: `meas_req` rises one cycle after a conversion is started. It stays high until a `meas_done` is sampled, and then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| on_battery | input | 1 | Device is running from the battery supply |
| conv_req | input | 1 | Software request for a conversion (pulse) |
| wdata | input | 8 | Register write data |
| aging_wr | input | 1 | Write strobe for the aging register |
| ctl_wr | input | 1 | Write strobe for the control register |
| meas_req | output | 1 | Measurement request to the sensor interface |
| meas_done | input | 1 | Sensor result valid (one cycle) |
| meas_code | input | 10 | Two's-complement temperature code, 0.25 °C per LSB |
| temp_code | output | 10 | Stored temperature code, index for the lookup |
| base_cap | input | TW | Base capacitance from the lookup |
| aging_q | output | 8 | Aging offset register, two's complement |
| ctl_q | output | 8 | Control register, bit 0 is the battery-conversion disable |
| conv_busy | output | 1 | Request bit, readable; 1 while a user conversion is pending or running |
| temp_msb | output | 8 | Temperature integer part |
| temp_lsb | output | 8 | Temperature fraction in bits 7:6 |
| trim | output | TW | Capacitor trim code |

## Verification
The sensor answers between one and four cycles after `meas_req` rises. The temperature registers change at the edge that samples `meas_done`. `trim` changes, and a user request's busy bit clears, one edge later. The bench therefore waits for its own sensor model to finish a response, or for `conv_busy` to fall. It then lets two falling edges pass before comparing anything.

For the tick interval, the bench sends exactly 63 ticks and confirms that no request appears over several further cycles. The 64th tick must then produce a request, and the bench checks for it.

// File: rtl/tcomp_sched.sv
module tcomp_sched #(
  parameter int TW     = 8,
  parameter int PERIOD = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_tick,
  input  logic          on_battery,
  input  logic          conv_req,
  input  logic [7:0]    wdata,
  input  logic          aging_wr,
  input  logic          ctl_wr,
  output logic          meas_req,
  input  logic          meas_done,
  input  logic [9:0]    meas_code,
  output logic [9:0]    temp_code,
  input  logic [TW-1:0] base_cap,
  output logic [7:0]    aging_q,
  output logic [7:0]    ctl_q,
  output logic          conv_busy,
  output logic [7:0]    temp_msb,
  output logic [7:0]    temp_lsb,
  output logic [TW-1:0] trim
);
  localparam int CW = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] LIMIT = CW'(PERIOD);
  localparam int SW = TW + 2;

  typedef enum logic [1:0] {S_IDLE, S_MEAS, S_APPLY} st_t;
  st_t st;

  logic [CW-1:0] cnt;
  logic          boot, dis_q, user_run, diff_q, first_q;
  logic [9:0]    code_q;
  logic [SW-1:0] sum;

  wire idle       = (st == S_IDLE);
  wire auto_due   = boot || (cnt == LIMIT);
  wire blocked    = on_battery && dis_q;
  wire start_user = idle && conv_busy;
  wire start_auto = idle && !conv_busy && auto_due && !blocked;
  wire skip_auto  = idle && !conv_busy && auto_due && blocked;

  assign sum = {2'b00, base_cap} + {{(SW-8){aging_q[7]}}, aging_q};

  wire [TW-1:0] clamped = sum[SW-1] ? '0 :
                          sum[TW]   ? '1 : sum[TW-1:0];

  assign meas_req  = (st == S_MEAS);
  assign temp_code = code_q;
  assign temp_msb  = code_q[9:2];
  assign temp_lsb  = {code_q[1:0], 6'b0};
  assign ctl_q     = {7'b0, dis_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      boot <= 1'b1;
    end else if (start_auto || skip_auto) begin
      cnt <= '0;
      boot <= 1'b0;
    end else if (sec_tick && cnt != LIMIT) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aging_q <= '0;
      dis_q   <= 1'b0;
    end else begin
      if (aging_wr) aging_q <= wdata;
      if (ctl_wr)   dis_q   <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          conv_busy <= 1'b0;
    else if (conv_req)                   conv_busy <= 1'b1;
    else if (st == S_APPLY && user_run)  conv_busy <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      user_run <= 1'b0;
      diff_q   <= 1'b0;
      first_q  <= 1'b1;
      code_q   <= '0;
      trim     <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start_user || start_auto) begin
            st       <= S_MEAS;
            user_run <= start_user;
          end
        end
        S_MEAS: begin
          if (meas_done) begin
            diff_q <= (meas_code != code_q);
            code_q <= meas_code;
            st     <= S_APPLY;
          end
        end
        S_APPLY: begin
          if (diff_q || user_run || first_q) trim <= clamped;
          first_q <= 1'b0;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module tcomp_sched_chk #(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          on_battery,
  input logic          meas_req,
  input logic          meas_done,
  input logic          conv_busy,
  input logic [7:0]    ctl_q,
  input logic [7:0]    temp_msb,
  input logic [7:0]    temp_lsb,
  input logic [TW-1:0] trim
);
  assert_lsb_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    temp_lsb[5:0] == 6'b0);

  assert_temp_only_on_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_done |=> $stable(temp_msb) && $stable(temp_lsb));

  assert_busy_clears_after_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_busy) |-> $past(meas_done, 2));

  assert_no_auto_on_battery_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(meas_req) && $past(on_battery) && $past(ctl_q[0])) |-> $past(conv_busy));

  assert_trim_timing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trim) |-> $past(meas_done, 2));

  assert_ctl_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[7:1] == 7'b0);

  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_req && !meas_done) |=> meas_req);

  assert_req_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_req && meas_done) |=> !meas_req);
endmodule

bind tcomp_sched tcomp_sched_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .on_battery(on_battery), .meas_req(meas_req),
  .meas_done(meas_done), .conv_busy(conv_busy), .ctl_q(ctl_q),
  .temp_msb(temp_msb), .temp_lsb(temp_lsb), .trim(trim)
);

// File: tb/tcomp_sched_bench.sv
`timescale 1ns/1ps
module tcomp_sched_bench;
  localparam int TW = 8;

  logic clk = 0, rst_n = 0;
  logic sec_tick = 0, on_battery = 0, conv_req = 0, aging_wr = 0, ctl_wr = 0;
  logic [7:0] wdata = 0;
  logic meas_req, meas_done = 0;
  logic [9:0] meas_code = 0, temp_code;
  logic [TW-1:0] base_cap, trim;
  logic [7:0] aging_q, ctl_q, temp_msb, temp_lsb;
  logic conv_busy;

  always #2.5 clk = ~clk;

  tcomp_sched u_tcomp_sched (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .on_battery(on_battery),
    .conv_req(conv_req), .wdata(wdata), .aging_wr(aging_wr), .ctl_wr(ctl_wr),
    .meas_req(meas_req), .meas_done(meas_done), .meas_code(meas_code),
    .temp_code(temp_code), .base_cap(base_cap), .aging_q(aging_q), .ctl_q(ctl_q),
    .conv_busy(conv_busy), .temp_msb(temp_msb), .temp_lsb(temp_lsb), .trim(trim)
  );

  function automatic logic [TW-1:0] lut(input logic [9:0] c);
    int v;
    v = int'(c) * 5 + 17;
    return v[TW-1:0];
  endfunction
  assign base_cap = lut(temp_code);

  int errors = 0, checks = 0, done_count = 0;
  logic [9:0] cur_code = 10'h065;
  logic [9:0] m_prev = 0;
  logic m_first = 1;
  logic [TW-1:0] m_trim = 0;
  logic [7:0] m_aging = 0;

  function automatic logic [TW-1:0] sat(input logic [TW-1:0] b, input logic [7:0] a);
    int s;
    s = int'(b) + int'($signed(a));
    if (s < 0) return '0;
    if (s > (1 << TW) - 1) return '1;
    return s[TW-1:0];
  endfunction

  function automatic void model(input logic [9:0] c, input logic user);
    if (c != m_prev || user || m_first) m_trim = sat(lut(c), m_aging);
    m_prev = c;
    m_first = 0;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    forever begin
      @(negedge clk);
      if (meas_req) begin
        repeat ($urandom_range(0, 3)) @(negedge clk);
        meas_code = cur_code;
        meas_done = 1;
        @(negedge clk);
        meas_done = 0;
        done_count++;
      end
    end
  end

  task automatic wait_done(input int old);
    while (done_count == old) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_regs(input string req);
    chk(req, {temp_msb, temp_lsb}, {m_prev[9:2], m_prev[1:0], 6'b0});
    chk(req, temp_code, m_prev);
    chk({req, " trim R7"}, trim, m_trim);
  endtask

  task automatic user_conv(input logic [9:0] c);
    int old;
    old = done_count;
    cur_code = c;
    @(negedge clk); conv_req = 1;
    @(negedge clk); conv_req = 0;
    chk("R4 busy set", conv_busy, 1);
    while (conv_busy) @(negedge clk);
    chk("R4 one conversion", done_count, old + 1);
    model(c, 1);
    check_regs("R4 user");
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sec_tick = 1;
      @(negedge clk); sec_tick = 0;
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
  endtask

  task automatic write_aging(input logic [7:0] v);
    @(negedge clk); aging_wr = 1; wdata = v;
    @(negedge clk); aging_wr = 0;
    m_aging = v;
    chk("R8 aging", aging_q, v);
  endtask

  task automatic write_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1; wdata = v;
    @(negedge clk); ctl_wr = 0;
    chk("R8 ctl", ctl_q, {7'b0, v[0]});
  endtask

  task automatic auto_conv(input logic [9:0] c);
    int old;
    old = done_count;
    cur_code = c;
    ticks(63);
    repeat (6) @(negedge clk);
    chk("R3 none before 64", done_count, old);
    chk("R3 req low", meas_req, 0);
    ticks(1);
    wait_done(old);
    model(c, 0);
    check_regs("R3/R6 auto");
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 temp", {temp_msb, temp_lsb}, 16'h0);
    chk("R1 trim", trim, 0);
    chk("R1 aging", aging_q, 0);
    chk("R1 ctl", ctl_q, 0);
    chk("R1 busy", conv_busy, 0);
    rst_n = 1;
    wait_done(0);
    chk("R1 boot conversion", done_count, 1);
    model(10'h065, 0);
    check_regs("R1 boot R2");
    chk("R2 25.25C", {temp_msb, temp_lsb}, 16'h1940);

    write_aging(8'h05);
    user_conv(10'h065);
    write_aging(8'hFD);
    auto_conv(10'h065);
    chk("R6 trim unchanged same temp", trim, sat(lut(10'h065), 8'h05));
    auto_conv(10'h066);

    user_conv(10'h3FF);
    chk("R2 -0.25C", {temp_msb, temp_lsb}, 16'hFFC0);

    write_ctl(8'hFF);
    on_battery = 1;
    begin
      int old;
      old = done_count;
      ticks(64);
      repeat (10) @(negedge clk);
      chk("R5 skipped on battery", done_count, old);
      check_regs("R5 regs held");
    end
    user_conv(10'h010);
    on_battery = 0;
    auto_conv(10'h011);
    on_battery = 1;
    write_ctl(8'h00);
    auto_conv(10'h012);
    on_battery = 0;

    write_aging(8'h7F);
    user_conv(10'd149);
    chk("R7 clamp high", trim, 8'hFF);
    write_aging(8'h80);
    user_conv(10'd100);
    chk("R7 clamp low", trim, 8'h00);

    for (int i = 0; i < 30; i++) begin
      logic [9:0] c;
      c = ($urandom_range(0, 2) == 0) ? m_prev : 10'($urandom);
      if ($urandom_range(0, 1) == 1) write_aging(8'($urandom));
      if ($urandom_range(0, 2) == 0) auto_conv(c);
      else user_conv(c);
    end
    finish_run();
  end
endmodule